// File: doc/BRIEF.md
# Snoop Inquire Response Unit

This block answers inquire cycles that an outside bus master runs against a small cache directory. The directory has an instruction side and a data side. Each side is direct-mapped and each entry keeps a tag and a MESI coherence state. An inquire is a one-cycle strobe that carries an address and an invalidate request. Two clocks after the strobe the block reports whether the line is present. It also reports whether the present line was dirty. It then moves the line to its new coherence state. The invalidate request alone decides that new state.

A dirty (modified) data line must leave the directory through a writeback before its state changes. The block raises a writeback request together with the dirty-hit indication and holds both until an acknowledge returns. Only then does it commit the line to shared or invalid. A fill port loads tags and states directly, so that a directory picture can be set up. Three inputs hold the outputs at a quiet value: an active-low reset, a synchronous re-initialise, and a stop-clock indication.

Top module: `inquire_snoop_unit`

## Requirements
- R1: An active-low asynchronous reset sets every entry of both sides to invalid and drives hitOut, hitModOut and wbReq low.
- R2: A strobe is sampled on a rising edge. hitOut takes its new value on the second rising edge after that edge. It keeps that value until the second edge after the next accepted strobe.
- R3: The directory index is address bits [3:0] and the tag is bits [11:4]. States are encoded I=00, S=01, E=10, M=11. A hit is a tag match on an instruction entry that is not 00, or on a data entry in 01, 10 or 11. Otherwise hitOut stays low.
- R4: A hit line takes its next state from the invalidate input: shared when that input was low, invalid when it was high. A later inquire to an invalidated line misses.
- R5: A data hit on a line in state 11 raises hitModOut and wbReq in the same cycle as hitOut. Both stay high until wbAck is sampled high. Only then does the line move to shared or invalid.
- R6: A miss leaves every entry unchanged, whatever the invalidate input is.
- R7: A strobe is accepted only when the block is idle. Strobes that arrive while an inquire is in flight or a writeback is pending are ignored.
- R8: While stopClk is high, hitOut and hitModOut read low and strobes are not accepted. The held result reappears when stopClk falls.
- R9: A synchronous initReq clears the outputs and abandons any pending writeback. The directory keeps its contents, so a dirty line that was being written back stays dirty.
- R10: The fill port writes one entry when the block is idle and is ignored otherwise. An instruction-side fill with any non-zero state is stored as shared (01).
- R11: The invalidate input counts only on the strobe's edge. Changing it in later cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initReq | input | 1 | Synchronous re-initialise of the control and outputs |
| stopClk | input | 1 | Stop-clock indication; quiets outputs and blocks strobes |
| inqStrobe | input | 1 | Inquire strobe, one cycle |
| inqAddr | input | 12 | Inquire address (tag and index) |
| invReq | input | 1 | Invalidate request, sampled with the strobe |
| wbAck | input | 1 | Writeback acknowledge |
| fillEn | input | 1 | Fill write enable |
| fillIside | input | 1 | Fill target: 1 instruction side, 0 data side |
| fillAddr | input | 12 | Fill address (tag and index) |
| fillState | input | 2 | Fill state code |
| hitOut | output | 1 | Inquire hit |
| hitModOut | output | 1 | Inquire hit on a modified line |
| wbReq | output | 1 | Writeback request |

## Verification
The bench first checks that a dirty line keeps its dirtiness until the acknowledge. A design that committed the state early would miss the second hitModOut when the line is inquired again. Strobes and fills sent during the writeback wait must leave no trace: a design that accepted them would invalidate a clean line or create a new one. A re-initialise during a pending writeback must leave the line dirty, and a design that cleared the state would lose the writeback. The bench also moves the invalidate input away from its strobe value in the following cycles, flips stop-clock while a result is held, and gives the instruction side a dirty fill code, which must never start a writeback.

// File: rtl/inq_pkg.sv
package inq_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch address and invalidate
    logic lookup;   // register the directory compare
    logic resolve;  // publish hit and apply clean updates
    logic wbDone;   // commit the dirty data line
    logic fillOk;   // fill port may write
  } dpCtl_t;
endpackage

// File: rtl/inq_store.sv
module inq_store
  import inq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initReq,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] inqAddr,
  input  logic              invReq,
  input  logic              fillEn,
  input  logic              fillIside,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [1:0]        fillState,
  output logic              hitReg,
  output logic              lkDMod
);
  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam int ENTRIES = 1 << IDX_W;

  logic [TAG_W-1:0] iTag [ENTRIES];
  logic [TAG_W-1:0] dTag [ENTRIES];
  mesi_t            iSt  [ENTRIES];
  mesi_t            dSt  [ENTRIES];

  logic [ADDR_W-1:0] capAddr;
  logic              capInv;
  logic              lkIHit, lkDHit;

  logic [IDX_W-1:0] capIdx, fillIdx;
  logic [TAG_W-1:0] capTag, fillTag;
  mesi_t            fillSt, iFillSt, nextSt;
  logic             fillI, fillD, updI, updD;

  assign capIdx  = capAddr[IDX_W-1:0];
  assign capTag  = capAddr[ADDR_W-1:IDX_W];
  assign fillIdx = fillAddr[IDX_W-1:0];
  assign fillTag = fillAddr[ADDR_W-1:IDX_W];
  assign fillSt  = mesi_t'(fillState);
  assign iFillSt = (fillSt == ST_I) ? ST_I : ST_S;
  assign nextSt  = capInv ? ST_I : ST_S;

  assign fillI = ctl.fillOk && fillEn && fillIside;
  assign fillD = ctl.fillOk && fillEn && !fillIside;
  assign updI  = ctl.resolve && lkIHit;
  assign updD  = (ctl.resolve && lkDHit && !lkDMod) || ctl.wbDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr <= '0;
      capInv  <= 1'b0;
    end else if (ctl.capture) begin
      capAddr <= inqAddr;
      capInv  <= invReq;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lkIHit <= 1'b0;
      lkDHit <= 1'b0;
      lkDMod <= 1'b0;
    end else if (ctl.lookup) begin
      lkIHit <= (iSt[capIdx] != ST_I) && (iTag[capIdx] == capTag);
      lkDHit <= (dSt[capIdx] != ST_I) && (dTag[capIdx] == capTag);
      lkDMod <= (dSt[capIdx] == ST_M) && (dTag[capIdx] == capTag);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          hitReg <= 1'b0;
    else if (initReq)   hitReg <= 1'b0;
    else if (ctl.resolve) hitReg <= lkIHit || lkDHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < ENTRIES; k++) begin
        iTag[k] <= '0;
        iSt[k]  <= ST_I;
      end
    end else if (fillI) begin
      iTag[fillIdx] <= fillTag;
      iSt[fillIdx]  <= iFillSt;
    end else if (updI) begin
      iSt[capIdx] <= nextSt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < ENTRIES; k++) begin
        dTag[k] <= '0;
        dSt[k]  <= ST_I;
      end
    end else if (fillD) begin
      dTag[fillIdx] <= fillTag;
      dSt[fillIdx]  <= fillSt;
    end else if (updD) begin
      dSt[capIdx] <= nextSt;
    end
  end
endmodule

// File: rtl/inq_ctrl.sv
module inq_ctrl
  import inq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   initReq,
  input  logic   stopClk,
  input  logic   inqStrobe,
  input  logic   wbAck,
  input  logic   lkDMod,
  output dpCtl_t ctl,
  output logic   wbPending
);
  typedef enum logic [1:0] {C_IDLE, C_LOOK, C_RES, C_WB} cst_t;
  cst_t cur, nxt;

  always_comb begin
    ctl         = '0;
    ctl.capture = (cur == C_IDLE) && inqStrobe && !stopClk && !initReq;
    ctl.fillOk  = (cur == C_IDLE) && !initReq;
    ctl.lookup  = (cur == C_LOOK) && !initReq;
    ctl.resolve = (cur == C_RES) && !initReq;
    ctl.wbDone  = (cur == C_WB) && wbAck && !initReq;
  end

  always_comb begin
    nxt = cur;
    unique case (cur)
      C_IDLE: if (ctl.capture) nxt = C_LOOK;
      C_LOOK: nxt = C_RES;
      C_RES:  nxt = lkDMod ? C_WB : C_IDLE;
      C_WB:   if (wbAck) nxt = C_IDLE;
      default: nxt = C_IDLE;
    endcase
    if (initReq) nxt = C_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cur <= C_IDLE;
    else       cur <= nxt;
  end

  assign wbPending = (cur == C_WB);
endmodule

// File: rtl/inquire_snoop_unit.sv
module inquire_snoop_unit
  import inq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initReq,
  input  logic              stopClk,
  input  logic              inqStrobe,
  input  logic [ADDR_W-1:0] inqAddr,
  input  logic              invReq,
  input  logic              wbAck,
  input  logic              fillEn,
  input  logic              fillIside,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [1:0]        fillState,
  output logic              hitOut,
  output logic              hitModOut,
  output logic              wbReq
);
  dpCtl_t ctl;
  logic   hitReg, lkDMod, wbPending;

  inq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .initReq(initReq), .stopClk(stopClk),
    .inqStrobe(inqStrobe), .wbAck(wbAck), .lkDMod(lkDMod),
    .ctl(ctl), .wbPending(wbPending)
  );

  inq_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rstN(rstN), .initReq(initReq), .ctl(ctl),
    .inqAddr(inqAddr), .invReq(invReq), .fillEn(fillEn),
    .fillIside(fillIside), .fillAddr(fillAddr), .fillState(fillState),
    .hitReg(hitReg), .lkDMod(lkDMod)
  );

  assign hitOut    = hitReg && !stopClk;
  assign hitModOut = wbPending && !stopClk;
  assign wbReq     = wbPending;
endmodule

// File: rtl/inquire_snoop_checker.sv
module inquire_snoop_checker (
  input logic clk,
  input logic rstN,
  input logic initReq,
  input logic stopClk,
  input logic inqStrobe,
  input logic wbAck,
  input logic hitOut,
  input logic hitModOut,
  input logic wbReq
);
  // R5: request held until acknowledge
  a_r5_wb_holds: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck && !initReq) |=> wbReq);

  // R5: request drops only after acknowledge (or re-initialise, R9)
  a_r5_wb_drop_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(wbReq) && !$past(initReq)) |-> $past(wbAck));

  // R5: a dirty hit is always also a hit
  a_r5_hitm_with_hit: assert property (@(posedge clk) disable iff (!rstN)
    hitModOut |-> hitOut);

  // R8: stop-clock quiets both hit outputs
  a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stopClk |-> (!hitOut && !hitModOut));

  // R2: hit changes only two edges after a strobe edge
  a_r2_hit_late_change: assert property (@(posedge clk) disable iff (!rstN || initReq)
    (!stopClk && !$past(stopClk) && !$past(initReq) && (hitOut != $past(hitOut)))
      |-> $past(inqStrobe, 3));
endmodule

bind inquire_snoop_unit inquire_snoop_checker u_chk (
  .clk(clk), .rstN(rstN), .initReq(initReq), .stopClk(stopClk),
  .inqStrobe(inqStrobe), .wbAck(wbAck), .hitOut(hitOut),
  .hitModOut(hitModOut), .wbReq(wbReq)
);

// File: tb/inquire_snoop_unit_bench.sv
module inquire_snoop_unit_bench;
  localparam int CLK_P = 10;
  localparam int AW = 12;
  localparam int IW = 4;
  localparam int NE = 1 << IW;

  logic clk = 1'b0;
  logic rstN, initReq, stopClk, inqStrobe, invReq, wbAck;
  logic fillEn, fillIside;
  logic [AW-1:0] inqAddr, fillAddr;
  logic [1:0] fillState;
  logic hitOut, hitModOut, wbReq;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  string curReq = "R1";

  always #(CLK_P/2) clk = ~clk;

  inquire_snoop_unit u_inquire_snoop_unit (
    .clk(clk), .rstN(rstN), .initReq(initReq), .stopClk(stopClk),
    .inqStrobe(inqStrobe), .inqAddr(inqAddr), .invReq(invReq), .wbAck(wbAck),
    .fillEn(fillEn), .fillIside(fillIside), .fillAddr(fillAddr),
    .fillState(fillState), .hitOut(hitOut), .hitModOut(hitModOut), .wbReq(wbReq)
  );

  // behavioural reference: states 0=I 1=S 2=E 3=M
  int mISt [NE];
  int mDSt [NE];
  int mITag[NE];
  int mDTag[NE];
  int phase = 0;
  int qIdx, qTag;
  bit qInv, mHit, mWb, hI, hD;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NE; k++) begin mISt[k] = 0; mDSt[k] = 0; mITag[k] = 0; mDTag[k] = 0; end
      phase = 0; mHit = 0; mWb = 0;
    end else if (initReq) begin
      phase = 0; mHit = 0; mWb = 0;
    end else begin
      case (phase)
        0: begin
          if (fillEn) begin
            if (fillIside) begin
              mISt[fillAddr % NE] = (fillState == 0) ? 0 : 1;
              mITag[fillAddr % NE] = fillAddr / NE;
            end else begin
              mDSt[fillAddr % NE] = fillState;
              mDTag[fillAddr % NE] = fillAddr / NE;
            end
          end
          if (inqStrobe && !stopClk) begin
            qIdx = inqAddr % NE; qTag = inqAddr / NE; qInv = invReq; phase = 1;
          end
        end
        1: phase = 2;
        2: begin
          hI = (mISt[qIdx] != 0) && (mITag[qIdx] == qTag);
          hD = (mDSt[qIdx] != 0) && (mDTag[qIdx] == qTag);
          mHit = hI || hD;
          if (hI) mISt[qIdx] = qInv ? 0 : 1;
          if (hD && mDSt[qIdx] == 3) begin
            mWb = 1; phase = 3;
          end else begin
            if (hD) mDSt[qIdx] = qInv ? 0 : 1;
            phase = 0;
          end
        end
        default: if (wbAck) begin
          mDSt[qIdx] = qInv ? 0 : 1; mWb = 0; phase = 0;
        end
      endcase
    end
  end

  task automatic compareAll();
    bit eHit, eHm, eWb;
    eHit = mHit && !stopClk;
    eHm  = mWb && !stopClk;
    eWb  = mWb;
    vectors++;
    if (hitOut !== eHit) begin
      fails++; $display("FAIL %s hitOut actual=%b expected=%b t=%0t", curReq, hitOut, eHit, $time);
    end
    if (hitModOut !== eHm) begin
      fails++; $display("FAIL %s hitModOut actual=%b expected=%b t=%0t", curReq, hitModOut, eHm, $time);
    end
    if (wbReq !== eWb) begin
      fails++; $display("FAIL %s wbReq actual=%b expected=%b t=%0t", curReq, wbReq, eWb, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic fill(bit iside, int tag, int idx, int st);
    fillEn = 1; fillIside = iside; fillAddr = AW'(tag * NE + idx); fillState = 2'(st);
    tick();
    fillEn = 0;
  endtask

  // strobe for one cycle, then flip invReq to show it is ignored (R11)
  task automatic inquire(int tag, int idx, bit inv, int waitN);
    inqStrobe = 1; inqAddr = AW'(tag * NE + idx); invReq = inv;
    tick();
    inqStrobe = 0; invReq = !inv;
    repeat (waitN) tick();
  endtask

  task automatic ack();
    wbAck = 1; tick(); wbAck = 0; tick();
  endtask

  // explicit expectation on top of the running compare
  task automatic expectOut(string tag, bit h, bit hm);
    vectors++;
    if (hitOut !== h || hitModOut !== hm) begin
      fails++;
      $display("FAIL %s directed actual=%b%b expected=%b%b", tag, hitOut, hitModOut, h, hm);
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; initReq = 0; stopClk = 0; inqStrobe = 0; invReq = 0; wbAck = 0;
    fillEn = 0; fillIside = 0; inqAddr = '0; fillAddr = '0; fillState = '0;
    // R1: reset state
    curReq = "R1";
    repeat (3) tick();
    expectOut("R1", 0, 0);
    rstN = 1;
    tick();

    // R10: directory setup, instruction dirty code coerced
    curReq = "R10";
    fill(1, 'h12, 3, 1);
    fill(0, 'h34, 5, 2);
    fill(0, 'h56, 7, 3);
    fill(0, 'h78, 9, 3);
    fill(1, 'h78, 9, 1);
    fill(1, 'hAA, 10, 3);
    fill(0, 'hBB, 11, 1);
    inquire('hAA, 10, 0, 3);
    expectOut("R10", 1, 0);

    // R3: index/tag compare
    curReq = "R3";
    inquire('h35, 5, 0, 3);
    expectOut("R3", 0, 0);
    inquire('h12, 3, 0, 3);
    expectOut("R3", 1, 0);

    // R6: miss with invalidate changes nothing
    curReq = "R6";
    inquire('h99, 5, 1, 3);
    inquire('h34, 5, 0, 3);
    expectOut("R6", 1, 0);

    // R2: hit falls only two edges after the next strobe
    curReq = "R2";
    inquire('h00, 0, 0, 0);
    expectOut("R2", 1, 0);
    tick();
    tick();
    expectOut("R2", 0, 0);

    // R4: invalidate then miss; clean shared stays
    curReq = "R4";
    inquire('h34, 5, 1, 3);
    inquire('h34, 5, 0, 3);
    expectOut("R4", 0, 0);
    inquire('hBB, 11, 0, 3);
    inquire('hBB, 11, 0, 3);
    expectOut("R4", 1, 0);

    // R5 + R7: dirty hit, strobe and fill during wait are ignored
    curReq = "R5";
    inquire('h56, 7, 0, 4);
    expectOut("R5", 1, 1);
    curReq = "R7";
    inquire('h12, 3, 1, 2);
    fill(0, 'h21, 2, 2);
    curReq = "R5";
    ack();
    inquire('h56, 7, 0, 3);
    expectOut("R5", 1, 0);
    curReq = "R7";
    inquire('h12, 3, 0, 3);
    expectOut("R7", 1, 0);
    inquire('h21, 2, 0, 3);
    expectOut("R10", 0, 0);

    // R11: invalidate taken only at the strobe edge; both sides hit
    curReq = "R11";
    inquire('h78, 9, 1, 3);
    ack();
    inquire('h78, 9, 0, 3);
    expectOut("R11", 0, 0);

    // R8: stop-clock quiets outputs and blocks strobes
    curReq = "R8";
    inquire('h12, 3, 0, 3);
    stopClk = 1;
    tick();
    expectOut("R8", 0, 0);
    inquire('h35, 5, 0, 3);
    stopClk = 0;
    tick();
    expectOut("R8", 1, 0);

    // R9: init during pending writeback keeps line dirty
    curReq = "R9";
    fill(0, 'h44, 13, 3);
    inquire('h44, 13, 1, 3);
    initReq = 1;
    tick();
    initReq = 0;
    tick();
    expectOut("R9", 0, 0);
    inquire('h44, 13, 1, 3);
    expectOut("R9", 1, 1);
    ack();
    inquire('h44, 13, 0, 3);
    expectOut("R9", 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule